// File: doc/BRIEF.md
# Real-Time Calendar with Protected Initialisation

The block keeps wall-clock time and calendar date in BCD inside the slow real-time clock domain. A two-stage divider (a coarse asynchronous stage followed by a fine synchronous stage) turns the input clock into a once-per-second tick. Each tick advances the seconds. Carries then ripple through minutes and hours, which count in 24-hour form. From the hours they reach the day of the month, the weekday, the month and a two-digit year. The month lengths include February in leap years.

Software reaches the block over a plain register bus with write enable, address, write data and a combinational read-data return. Changing the time, date or divider takes three steps. First, a two-byte key opens the write guard. Next, an initialisation request is raised and software waits for the hardware flag that shows the counters have stopped. Only then are the new values written. Dropping the request restarts counting from a fresh second. A resync flag that software clears reports when the readable calendar is valid again.

Top module: `rtc_calendar`

Register word addresses used in the requirements: 0 time, 1 date, 2 control, 3 status, 4 divider, 5 key. Status bits are: bit 0 init request, bit 1 init flag, bit 2 resync flag, bit 3 calendar-set flag.

## Requirements
- R1: After reset the registers read as follows. Time reads 0x00000000. Date reads 0x00002101, which is year 00, weekday 1, month 01 and day 01. Control reads 0. Status reads 0x4, with only the resync flag set. The divider reads 0x007F00FF.
- R2: Writing 0xCA and then 0x53 to the key register opens the guard. Any other key write closes it, and so does a wrong value after 0xCA. While the guard is closed, writes to time, date, divider, control (bit 6, the hour-format bit, 0 = 24-hour) and the init request bit are ignored.
- R3: A write that sets the init request makes the init flag read 1 two clock cycles after the write edge. Clearing the request drops the flag two cycles after that write.
- R4: Writes to time, date and divider take effect only while the guard is open and the init flag is 1. At any other time they are ignored.
- R5: While the init flag is 1 no second tick occurs and the calendar holds its value. After the flag falls, the divider restarts from zero, so the first tick appears (A+1)(S+1) cycles after the flag clears.
- R6: While counting runs, ticks recur every (A+1)(S+1) clock cycles. A sits in divider bits 22:16 and S in bits 14:0.
- R7: Time is BCD. Seconds sit in bits 6:0, minutes in 14:8 and hours in 21:16. Seconds 59 and minutes 59 each wrap to 00 and carry. Hour 23 wraps to 00 and advances both the date and the weekday, where 7 (Sunday) wraps to 1 (Monday).
- R8: Date is BCD. Day sits in bits 5:0, month in 12:8, weekday in 15:13 and year in 23:16. April, June, September and November have 30 days; the other months have 31. February has 29 days when the year is a multiple of 4 and 28 otherwise. December 31 rolls to January 1 with the year incremented, and year 99 rolls to 00.
- R9: Writing status with bit 2 = 0 clears the resync flag without needing the key. The flag reads 1 again two cycles after that write.
- R10: Status bit 3 reads 1 exactly when the year field is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Real-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sec_tick | output | 1 | One-cycle pulse; the calendar advances on the following edge |

## Verification
The rollover logic is tested with several starting points, each loaded just short of a boundary. Seconds near the end of a minute separate the minute carry from the hour carry. The last second of February 28 is tried in a non-leap year and in a leap year, which shows whether the leap test is applied. The last second of February 29, April 30 and December 31 of year 99 expose the 30-day table, the month wrap and the year wrap, and with the year wrap the calendar-set flag as well. A wrong key order, a relock while initialising, and writes made outside initialisation each show that the two gates act independently. Tick spacing is measured both in steady counting and just after leaving initialisation.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam logic [2:0] ADR_TIME  = 3'd0;
  localparam logic [2:0] ADR_DATE  = 3'd1;
  localparam logic [2:0] ADR_CTRL  = 3'd2;
  localparam logic [2:0] ADR_STAT  = 3'd3;
  localparam logic [2:0] ADR_DIV   = 3'd4;
  localparam logic [2:0] ADR_KEY   = 3'd5;

  localparam logic [7:0] KEY_OPEN_A = 8'hCA;
  localparam logic [7:0] KEY_OPEN_B = 8'h53;

  typedef struct packed {
    logic [7:0] year;
    logic [2:0] wday;
    logic [4:0] month;
    logic [5:0] day;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_t;

  // BCD increment of a two-digit value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // year is a multiple of four: tens*10 + ones == 2*tens + ones (mod 4)
  function automatic logic is_leap(input logic [7:0] y);
    int s;
    s = 2 * int'(y[7:4]) + int'(y[3:0]);
    return (s % 4) == 0;
  endfunction

  // last valid BCD day of a BCD month
  function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_key_guard.sv
module rtc_key_guard
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output logic       unlocked
);

  typedef enum logic [1:0] {G_SHUT, G_HALF, G_OPEN} guard_e;
  guard_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= G_SHUT;
    end else if (key_wr) begin
      if (key_byte == KEY_OPEN_A)
        st_q <= G_HALF;
      else if (st_q == G_HALF && key_byte == KEY_OPEN_B)
        st_q <= G_OPEN;
      else
        st_q <= G_SHUT;
    end
  end

  assign unlocked = (st_q == G_OPEN);

endmodule

// File: rtl/rtc_init_sync.sv
module rtc_init_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_req,
  input  logic rsf_clear,
  output logic init_flag,
  output logic rsf
);

  localparam int CW = $clog2(SYNC_STAGES + 1);

  logic [SYNC_STAGES-1:0] shift_q;
  logic [CW-1:0]          wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[SYNC_STAGES-2:0], init_req};
  end

  assign init_flag = shift_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsf    <= 1'b1;
      wait_q <= '0;
    end else if (rsf_clear) begin
      rsf    <= 1'b0;
      wait_q <= CW'(SYNC_STAGES);
    end else if (wait_q != '0) begin
      wait_q <= wait_q - CW'(1);
      if (wait_q == CW'(1)) rsf <= 1'b1;
    end
  end

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int ASYNC_W = 7,
  parameter int SYNC_W  = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [ASYNC_W-1:0] div_a,
  input  logic [SYNC_W-1:0]  div_s,
  output logic               tick
);

  logic [ASYNC_W-1:0] a_q;
  logic [SYNC_W-1:0]  s_q;
  logic               a_end, s_end;

  assign a_end = (a_q >= div_a);
  assign s_end = (s_q >= div_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      s_q <= '0;
    end else if (!run) begin
      a_q <= '0;
      s_q <= '0;
    end else if (a_end) begin
      a_q <= '0;
      s_q <= s_end ? '0 : s_q + SYNC_W'(1);
    end else begin
      a_q <= a_q + ASYNC_W'(1);
    end
  end

  assign tick = run && a_end && s_end;

endmodule

// File: rtl/rtc_bcd_cal.sv
module rtc_bcd_cal
  import rtc_cal_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        ld_time,
  input  logic        ld_date,
  input  logic [31:0] wr_data,
  output cal_t        cal,
  output logic        day_wrap
);

  cal_t nxt;
  logic sec_wrap, min_wrap, hour_wrap, mon_wrap;

  assign sec_wrap  = (cal.sec   == 7'h59);
  assign min_wrap  = (cal.min   == 7'h59);
  assign hour_wrap = (cal.hour  == 6'h23);
  assign day_wrap  = (cal.day   == month_last(cal.month, cal.year));
  assign mon_wrap  = (cal.month == 5'h12);

  always_comb begin
    nxt = cal;
    if (sec_wrap) begin
      nxt.sec = '0;
      if (min_wrap) begin
        nxt.min = '0;
        if (hour_wrap) begin
          nxt.hour = '0;
          nxt.wday = (cal.wday == 3'd7) ? 3'd1 : cal.wday + 3'd1;
          if (day_wrap) begin
            nxt.day = 6'h01;
            if (mon_wrap) begin
              nxt.month = 5'h01;
              nxt.year  = (cal.year == 8'h99) ? 8'h00 : bcd_inc(cal.year);
            end else begin
              nxt.month = 5'(bcd_inc({3'b0, cal.month}));
            end
          end else begin
            nxt.day = 6'(bcd_inc({2'b0, cal.day}));
          end
        end else begin
          nxt.hour = 6'(bcd_inc({2'b0, cal.hour}));
        end
      end else begin
        nxt.min = 7'(bcd_inc({1'b0, cal.min}));
      end
    end else begin
      nxt.sec = 7'(bcd_inc({1'b0, cal.sec}));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal <= '{year: 8'h00, wday: 3'd1, month: 5'h01, day: 6'h01,
               hour: 6'h00, min: 7'h00, sec: 7'h00};
    end else if (ld_time) begin
      cal.sec  <= wr_data[6:0];
      cal.min  <= wr_data[14:8];
      cal.hour <= wr_data[21:16];
    end else if (ld_date) begin
      cal.day   <= wr_data[5:0];
      cal.month <= wr_data[12:8];
      cal.wday  <= wr_data[15:13];
      cal.year  <= wr_data[23:16];
    end else if (tick) begin
      cal <= nxt;
    end
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ASYNC_W     = 7,
  parameter int SYNC_W      = 15,
  parameter int ASYNC_RST   = 127,
  parameter int SYNC_RST    = 255,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sec_tick
);

  localparam int DIV_S_LSB = 0;
  localparam int DIV_A_LSB = 16;

  cal_t               cal_q;
  logic               unlocked, init_flag, rsf, day_wrap;
  logic               init_req, fmt_q;
  logic [ASYNC_W-1:0] div_a_q;
  logic [SYNC_W-1:0]  div_s_q;
  logic               key_wr, cal_ok, ld_time, ld_date, ld_div, rsf_clear;
  logic               cal_set;
  logic [31:0]        time_word, date_word;

  assign key_wr    = bus_we && bus_addr == ADR_KEY;
  assign cal_ok    = unlocked && init_flag;
  assign ld_time   = bus_we && bus_addr == ADR_TIME && cal_ok;
  assign ld_date   = bus_we && bus_addr == ADR_DATE && cal_ok;
  assign ld_div    = bus_we && bus_addr == ADR_DIV  && cal_ok;
  assign rsf_clear = bus_we && bus_addr == ADR_STAT && !bus_wdata[2];

  rtc_key_guard u_guard (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
    .key_byte(bus_wdata[7:0]), .unlocked(unlocked)
  );

  rtc_init_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .init_req(init_req),
    .rsf_clear(rsf_clear), .init_flag(init_flag), .rsf(rsf)
  );

  rtc_prescaler #(.ASYNC_W(ASYNC_W), .SYNC_W(SYNC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(!init_flag),
    .div_a(div_a_q), .div_s(div_s_q), .tick(sec_tick)
  );

  rtc_bcd_cal u_cal (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .ld_time(ld_time),
    .ld_date(ld_date), .wr_data(bus_wdata), .cal(cal_q), .day_wrap(day_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_req <= 1'b0;
      fmt_q    <= 1'b0;
      div_a_q  <= ASYNC_W'(ASYNC_RST);
      div_s_q  <= SYNC_W'(SYNC_RST);
    end else begin
      if (bus_we && bus_addr == ADR_STAT && unlocked) init_req <= bus_wdata[0];
      if (bus_we && bus_addr == ADR_CTRL && unlocked) fmt_q    <= bus_wdata[6];
      if (ld_div) begin
        div_a_q <= bus_wdata[DIV_A_LSB +: ASYNC_W];
        div_s_q <= bus_wdata[DIV_S_LSB +: SYNC_W];
      end
    end
  end

  assign cal_set   = (cal_q.year != 8'h00);
  assign time_word = {10'b0, cal_q.hour, 1'b0, cal_q.min, 1'b0, cal_q.sec};
  assign date_word = {8'b0, cal_q.year, cal_q.wday, cal_q.month, 2'b0, cal_q.day};

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_TIME: bus_rdata = time_word;
      ADR_DATE: bus_rdata = date_word;
      ADR_CTRL: bus_rdata[6] = fmt_q;
      ADR_STAT: bus_rdata[3:0] = {cal_set, rsf, init_flag, init_req};
      ADR_DIV: begin
        bus_rdata[DIV_A_LSB +: ASYNC_W] = div_a_q;
        bus_rdata[DIV_S_LSB +: SYNC_W]  = div_s_q;
      end
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        init_req,
  input logic        init_flag,
  input logic        unlocked,
  input logic        sec_tick,
  input logic        rsf,
  input logic [31:0] time_word
);

  // R3
  initf_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_flag) |-> $past(init_req, 2));

  // R5
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_flag |-> !sec_tick);

  // R7
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && time_word[6:0] == 7'h59) |=> time_word[6:0] == 7'h00);

  // R2
  locked_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0 && !unlocked && !sec_tick) |=> $stable(time_word));

  // R2
  unlock_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(bus_we && bus_addr == 3'd5 && bus_wdata[7:0] == 8'h53));

  // R4
  outside_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0 && !init_flag && !sec_tick) |=> $stable(time_word));

  // R9
  rsf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rsf) |=> !rsf);

endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .init_req(init_req), .init_flag(init_flag),
  .unlocked(unlocked), .sec_tick(sec_tick), .rsf(rsf), .time_word(time_word)
);

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sec_tick;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  rtc_calendar uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic unlock();
    wr(3'd5, 32'hCA);
    wr(3'd5, 32'h53);
  endtask

  task automatic set_cal(input logic [31:0] t, input logic [31:0] d);
    unlock();
    wr(3'd3, 32'h5);
    repeat (2) @(negedge clk);
    wr(3'd0, t);
    wr(3'd1, d);
    wr(3'd3, 32'h4);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      while (!sec_tick) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rd_chk("R1 time", 3'd0, 32'h0);
    rd_chk("R1 date", 3'd1, 32'h00002101);
    rd_chk("R1 ctrl", 3'd2, 32'h0);
    rd_chk("R1 status", 3'd3, 32'h4);
    rd_chk("R1 divider", 3'd4, 32'h007F00FF);
  endtask

  task automatic t_wrong_key();
    wr(3'd5, 32'hCA); wr(3'd5, 32'h12); wr(3'd5, 32'h53);
    wr(3'd3, 32'h5);
    repeat (3) @(negedge clk);
    rd_chk("R2 init request ignored while locked", 3'd3, 32'h4);
    wr(3'd2, 32'h40);
    rd_chk("R2 control ignored while locked", 3'd2, 32'h0);
  endtask

  task automatic t_outside_init();
    unlock();
    wr(3'd0, 32'h00123456);
    rd_chk("R4 time ignored outside init", 3'd0, 32'h0);
    wr(3'd4, 32'h00010002);
    rd_chk("R4 divider ignored outside init", 3'd4, 32'h007F00FF);
    wr(3'd2, 32'h40);
    rd_chk("R2 control written when open", 3'd2, 32'h40);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_handshake();
    int n;
    wr(3'd3, 32'h5);
    rd_chk("R3 flag low at write", 3'd3, 32'h5);
    @(negedge clk);
    rd_chk("R3 flag low one cycle later", 3'd3, 32'h5);
    @(negedge clk);
    rd_chk("R3 flag high two cycles later", 3'd3, 32'h7);
    wr(3'd4, 32'h00010002);
    rd_chk("R4 divider written in init", 3'd4, 32'h00010002);
    wr(3'd3, 32'h4);
    rd_chk("R3 flag still high after clear", 3'd3, 32'h6);
    n = 0;
    while (!sec_tick) begin @(negedge clk); n++; end
    chk("R5 first tick after init exit", n, 7);
    rd_chk("R3 flag low after clear", 3'd3, 32'h4);
  endtask

  task automatic t_period();
    int n;
    while (!sec_tick) @(negedge clk);
    @(negedge clk);
    n = 1;
    while (!sec_tick) begin @(negedge clk); n++; end
    chk("R6 tick period", n, 6);
  endtask

  task automatic t_freeze();
    int seen;
    unlock();
    wr(3'd3, 32'h5);
    repeat (2) @(negedge clk);
    wr(3'd0, 32'h00101010);
    seen = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (sec_tick) seen++; end
    chk("R5 no tick while in init", seen, 0);
    rd_chk("R5 time held in init", 3'd0, 32'h00101010);
    wr(3'd3, 32'h4);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_rollovers();
    set_cal(32'h00105959, 32'h00232228);
    wait_ticks(1);
    rd_chk("R7 minute carry", 3'd0, 32'h00110000);
    set_cal(32'h00235958, 32'h0023E228);
    wait_ticks(1);
    rd_chk("R7 seconds step", 3'd0, 32'h00235959);
    wait_ticks(1);
    rd_chk("R7 midnight wrap", 3'd0, 32'h0);
    rd_chk("R8 Feb 28 non-leap, weekday 7 to 1", 3'd1, 32'h00232301);
    set_cal(32'h00235959, 32'h00242228);
    wait_ticks(1);
    rd_chk("R8 Feb 28 leap year", 3'd1, 32'h00244229);
    set_cal(32'h00235959, 32'h00244229);
    wait_ticks(1);
    rd_chk("R8 Feb 29 to Mar 1", 3'd1, 32'h00246301);
    set_cal(32'h00235959, 32'h00246430);
    wait_ticks(1);
    rd_chk("R8 Apr 30 to May 1", 3'd1, 32'h00248501);
    set_cal(32'h00235959, 32'h0099B231);
    rd_chk("R10 flag with year 99", 3'd3, 32'hC);
    wait_ticks(1);
    rd_chk("R8 year wrap", 3'd1, 32'h0000C101);
    rd_chk("R10 flag with year 00", 3'd3, 32'h4);
  endtask

  task automatic t_relock();
    logic [31:0] held;
    unlock();
    wr(3'd3, 32'h5);
    repeat (2) @(negedge clk);
    wr(3'd5, 32'hFF);
    rd(3'd0, held);
    wr(3'd0, 32'h00010203);
    rd_chk("R2 time ignored after relock", 3'd0, held);
    wr(3'd3, 32'h4);
    repeat (3) @(negedge clk);
    rd_chk("R2 init clear ignored after relock", 3'd3, 32'h7);
    unlock();
    wr(3'd3, 32'h4);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_rsf();
    wr(3'd5, 32'hFF);
    wr(3'd3, 32'h0);
    rd_chk("R9 resync cleared", 3'd3, 32'h0);
    @(negedge clk);
    rd_chk("R9 resync still low", 3'd3, 32'h0);
    @(negedge clk);
    rd_chk("R9 resync set again", 3'd3, 32'h4);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wrong_key();
    t_outside_init();
    t_handshake();
    t_period();
    t_freeze();
    t_rollovers();
    t_relock();
    t_rsf();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule